// File: doc/BRIEF.md
# Battery-Backed SRAM Power Supervisor

This block sits between a host and a byte-wide static memory whose contents are kept alive by a backup cell. Each clock it samples an 8-bit supply code, where one step is 25 mV, so code 200 means 5.00 V. It compares the code against a set of levels. The upper two levels depend on a tolerance-select input: a tight (5%) setting or a loose (10%) setting. Every comparison is debounced before it is acted on. From the debounced levels the block decides whether host strobes may reach the memory, whether the memory must be locked with its data drivers floating, and whether the backup cell should power the array.

A new part leaves the factory with its backup cell isolated. The block keeps the cell disconnected until the supply first rises clearly into the operating range. After that the cell is switched in whenever the supply sags below roughly 3.0 V. The host strobes pass through a single register stage while operation is allowed, and are forced inactive otherwise. A 2-bit status code reports the current mode.

Top module: `nvs_supervisor`

## Requirements
- R1: From a synchronous active-high reset, status is 0 (sealed), the backup flag is low, all three gated strobes are high (inactive) and the data-drive enable is low.
- R2: With tol_wide_i = 0, the block enters normal mode (status 1) only when the code is 191 or higher. Once in normal mode it stays there at code 181, and it falls to protected mode (status 2) at code 180 or lower. In protected mode, code 190 does not restore normal mode.
- R3: With tol_wide_i = 1, the block enters normal mode only at code 181 or higher. Once in normal mode it stays there at code 171, and it falls to protected mode at code 170 or lower. In protected mode, code 180 does not restore normal mode.
- R4: In any mode other than normal, the chip, write and output strobes at the outputs are held high and the data-drive enable is low, whatever the host strobes do.
- R5: In normal mode, each gated strobe equals its host strobe one clock later. The data-drive enable is high exactly when the chip and output strobes were low and the write strobe was high on the previous clock.
- R6: A write in progress is cut off: if the host holds chip and write strobes low while the supply drops into protection, the gated write strobe returns high with no change on the host side.
- R7: Once the seal is released, a code of 119 or lower gives status 3 with the backup flag high. A code of 120 or higher removes the backup flag and reports protected mode until the full-operation level is reached.
- R8: Until the code has exceeded 170 (0 to 170 do not count), a code below 120 gives status 0 with the backup flag low, and a code from 120 up to the full-operation level gives status 2. Once released, the seal stays released until reset.
- R9: A level change must be present on 4 consecutive samples to take effect. A change lasting 3 samples leaves the mode unchanged. A change lasting 4 samples is acted on.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vcode_i | input | 8 | Supply code, 25 mV per step |
| tol_wide_i | input | 1 | 0 = 5% tolerance levels, 1 = 10% tolerance levels |
| ce_n_i | input | 1 | Host chip strobe, active low |
| we_n_i | input | 1 | Host write strobe, active low |
| oe_n_i | input | 1 | Host output strobe, active low |
| ce_n_o | output | 1 | Gated chip strobe to memory, active low |
| we_n_o | output | 1 | Gated write strobe to memory, active low |
| oe_n_o | output | 1 | Gated output strobe to memory, active low |
| dq_oe_o | output | 1 | Enable for the memory data drivers |
| bat_on_o | output | 1 | Backup cell connected to the array |
| status_o | output | 2 | 0 sealed, 1 normal, 2 protected, 3 backup |

## Verification
The supply code is stepped onto each side of every level, under both tolerance settings, and in both directions. This separates the entry level from the exit level and shows that the levels move with the select input. The sealed path is tried with codes that stop at 170 and codes that pass it, which distinguishes "never released" from "released and sticky". Dips lasting three and four samples show whether the debounce length is off by one. Read, write and all-active strobe patterns are driven in normal and locked modes, including a write held across a supply drop, so that pass-through, blocking and the drive-enable decode can be told apart.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ST_SEALED  = 2'd0,
    ST_NORMAL  = 2'd1,
    ST_PROTECT = 2'd2,
    ST_BACKUP  = 2'd3
  } pwr_state_e;

  // debounced level indices
  localparam int LV_FULL   = 0;  // above full-operation level
  localparam int LV_PROT   = 1;  // at or below protection level
  localparam int LV_SWITCH = 2;  // below backup switchover
  localparam int LV_SEAL   = 3;  // above seal-release level
  localparam int NUM_LV    = 4;
endpackage

// File: rtl/nvs_level_filter.sv
module nvs_level_filter #(
  parameter int  FILT_LEN = 4,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_q;
  logic          filt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q  <= '0;
      filt_q <= RST_VAL;
    end else if (raw_i == filt_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q  <= '0;
      filt_q <= raw_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R9: the debounced level only ever moves toward the value last sampled
  a_r9_follows_raw: assert property (@(posedge clk_i) disable iff (rst_i)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(raw_i)))
    else $error("filter moved away from its input");
endmodule

// File: rtl/nvs_power_fsm.sv
module nvs_power_fsm
  import nvs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NUM_LV-1:0] lv_i,
  output pwr_state_e       state_o
);
  pwr_state_e state_q, state_d;
  logic       seal_open_q;

  always_comb begin
    state_d = state_q;
    if (lv_i[LV_SWITCH]) begin
      state_d = seal_open_q ? ST_BACKUP : ST_SEALED;
    end else if (state_q == ST_NORMAL) begin
      if (lv_i[LV_PROT]) state_d = ST_PROTECT;
    end else begin
      state_d = lv_i[LV_FULL] ? ST_NORMAL : ST_PROTECT;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q     <= ST_SEALED;
      seal_open_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (lv_i[LV_SEAL]) seal_open_q <= 1'b1;
    end
  end

  assign state_o = state_q;

  // R8: seal, once opened, never closes again before reset
  a_r8_seal_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    seal_open_q |=> seal_open_q)
    else $error("seal closed again");

  // R7/R8: backup mode is reachable only with the seal released
  a_r8_backup_needs_seal: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_BACKUP) |-> seal_open_q)
    else $error("backup entered while sealed");
endmodule

// File: rtl/nvs_strobe_gate.sv
module nvs_strobe_gate
  import nvs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  pwr_state_e state_i,
  input  logic       ce_n_i,
  input  logic       we_n_i,
  input  logic       oe_n_i,
  output logic       ce_n_o,
  output logic       we_n_o,
  output logic       oe_n_o,
  output logic       dq_oe_o,
  output logic       bat_on_o,
  output logic [1:0] status_o
);
  logic open_access;
  assign open_access = (state_i == ST_NORMAL);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ce_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      dq_oe_o  <= 1'b0;
      bat_on_o <= 1'b0;
      status_o <= ST_SEALED;
    end else begin
      ce_n_o   <= open_access ? ce_n_i : 1'b1;
      we_n_o   <= open_access ? we_n_i : 1'b1;
      oe_n_o   <= open_access ? oe_n_i : 1'b1;
      dq_oe_o  <= open_access & ~ce_n_i & ~oe_n_i & we_n_i;
      bat_on_o <= (state_i == ST_BACKUP);
      status_o <= state_i;
    end
  end

  // R4: any locked mode blocks the memory on the next clock
  a_r4_locked_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i != ST_NORMAL) |=> (ce_n_o && we_n_o && oe_n_o && !dq_oe_o))
    else $error("strobe leaked while locked");

  // R5: normal mode forwards the host write strobe with one clock delay
  a_r5_write_forward: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == ST_NORMAL) |=> (we_n_o == $past(we_n_i)))
    else $error("write strobe not forwarded");
endmodule

// File: rtl/nvs_supervisor.sv
module nvs_supervisor
  import nvs_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int FILT_LEN    = 4,
  parameter int FULL_NARROW = 190,
  parameter int PROT_NARROW = 180,
  parameter int FULL_WIDE   = 180,
  parameter int PROT_WIDE   = 170,
  parameter int SEAL_LEVEL  = 170,
  parameter int SWITCH_LVL  = 120
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] vcode_i,
  input  logic              tol_wide_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              dq_oe_o,
  output logic              bat_on_o,
  output logic [1:0]        status_o
);
  localparam logic [CODE_W-1:0] FULL_N = CODE_W'(FULL_NARROW);
  localparam logic [CODE_W-1:0] PROT_N = CODE_W'(PROT_NARROW);
  localparam logic [CODE_W-1:0] FULL_W = CODE_W'(FULL_WIDE);
  localparam logic [CODE_W-1:0] PROT_W = CODE_W'(PROT_WIDE);
  localparam logic [CODE_W-1:0] SEAL_C = CODE_W'(SEAL_LEVEL);
  localparam logic [CODE_W-1:0] SW_C   = CODE_W'(SWITCH_LVL);
  // reset each level to the pessimistic side: low supply, sealed
  localparam logic [NUM_LV-1:0] LV_RST = 4'b0110;

  logic [CODE_W-1:0] full_thr, prot_thr;
  logic [NUM_LV-1:0] lv_raw, lv_filt;
  pwr_state_e        state;

  assign full_thr = tol_wide_i ? FULL_W : FULL_N;
  assign prot_thr = tol_wide_i ? PROT_W : PROT_N;

  assign lv_raw[LV_FULL]   = (vcode_i >  full_thr);
  assign lv_raw[LV_PROT]   = (vcode_i <= prot_thr);
  assign lv_raw[LV_SWITCH] = (vcode_i <  SW_C);
  assign lv_raw[LV_SEAL]   = (vcode_i >  SEAL_C);

  for (genvar g = 0; g < NUM_LV; g++) begin : g_filt
    nvs_level_filter #(
      .FILT_LEN (FILT_LEN),
      .RST_VAL  (LV_RST[g])
    ) i_filt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .raw_i  (lv_raw[g]),
      .filt_o (lv_filt[g])
    );
  end

  nvs_power_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .lv_i    (lv_filt),
    .state_o (state)
  );

  nvs_strobe_gate i_gate (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .state_i  (state),
    .ce_n_i   (ce_n_i),
    .we_n_i   (we_n_i),
    .oe_n_i   (oe_n_i),
    .ce_n_o   (ce_n_o),
    .we_n_o   (we_n_o),
    .oe_n_o   (oe_n_o),
    .dq_oe_o  (dq_oe_o),
    .bat_on_o (bat_on_o),
    .status_o (status_o)
  );

  // R7: the backup flag and the backup status code move together
  a_r7_flag_matches_status: assert property (@(posedge clk_i) disable iff (rst_i)
    bat_on_o == (status_o == 2'd3))
    else $error("backup flag disagrees with status");
endmodule

// File: tb/test_nvs_supervisor.sv
module test_nvs_supervisor;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] vcode;
  logic       tol_wide;
  logic       ce_n, we_n, oe_n;
  logic       ce_n_o, we_n_o, oe_n_o, dq_oe_o, bat_on_o;
  logic [1:0] status_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvs_supervisor i_nvs_supervisor (
    .clk_i(clk), .rst_i(rst), .vcode_i(vcode), .tol_wide_i(tol_wide),
    .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .ce_n_o(ce_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
    .dq_oe_o(dq_oe_o), .bat_on_o(bat_on_o), .status_o(status_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // apply a code and let filter, state and output stages settle
  task automatic set_code(int v);
    vcode = 8'(v);
    cyc(10);
  endtask

  task automatic t_reset;
    rst = 1'b1; vcode = 8'd0; tol_wide = 1'b0;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 status", status_o, 0);
    check("R1 bat", bat_on_o, 0);
    check("R1 strobes", {ce_n_o, we_n_o, oe_n_o}, 7);
    check("R1 dq_oe", dq_oe_o, 0);
  endtask

  task automatic t_seal;
    set_code(0);   check("R8 sealed low", status_o, 0);
    check("R8 no bat while sealed", bat_on_o, 0);
    set_code(150); check("R8 sealed mid", status_o, 2);
    set_code(170); check("R8 at 170 still protect", status_o, 2);
    set_code(100); check("R8 170 did not release", status_o, 0);
    check("R8 bat stays low", bat_on_o, 0);
  endtask

  task automatic t_narrow;
    tol_wide = 1'b0;
    set_code(190); check("R2 190 not enough", status_o, 2);
    set_code(191); check("R2 191 normal", status_o, 1);
    set_code(181); check("R2 181 holds normal", status_o, 1);
    set_code(180); check("R2 180 protects", status_o, 2);
    set_code(190); check("R2 190 no return", status_o, 2);
    set_code(60);  check("R8 seal released sticky", status_o, 3);
  endtask

  task automatic t_wide;
    tol_wide = 1'b1;
    set_code(180); check("R3 180 not enough", status_o, 2);
    set_code(181); check("R3 181 normal", status_o, 1);
    set_code(171); check("R3 171 holds normal", status_o, 1);
    set_code(170); check("R3 170 protects", status_o, 2);
    set_code(180); check("R3 180 no return", status_o, 2);
    tol_wide = 1'b0;
  endtask

  task automatic t_backup;
    set_code(119); check("R7 119 backup", status_o, 3);
    check("R7 bat on", bat_on_o, 1);
    set_code(120); check("R7 120 leaves backup", status_o, 2);
    check("R7 bat off", bat_on_o, 0);
    set_code(100); check("R7 backup again", bat_on_o, 1);
  endtask

  task automatic t_filter;
    set_code(200); check("R9 start normal", status_o, 1);
    vcode = 8'd100; cyc(3); vcode = 8'd200; cyc(10);
    check("R9 3-sample dip ignored", status_o, 1);
    vcode = 8'd100; cyc(4); vcode = 8'd200; cyc(3);
    check("R9 4-sample dip acted on", status_o, 3);
    cyc(10);
    check("R9 recovers", status_o, 1);
  endtask

  task automatic t_gating;
    set_code(200);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; cyc(2);
    check("R5 read ce", ce_n_o, 0);
    check("R5 read oe", oe_n_o, 0);
    check("R5 read dq_oe", dq_oe_o, 1);
    oe_n = 1'b1; we_n = 1'b0; cyc(2);
    check("R5 write we", we_n_o, 0);
    check("R5 write dq_oe", dq_oe_o, 0);
    // write held across a supply drop
    vcode = 8'd150; cyc(10);
    check("R6 write cut", we_n_o, 1);
    check("R6 status", status_o, 2);
    oe_n = 1'b0; cyc(2);
    check("R4 locked strobes", {ce_n_o, we_n_o, oe_n_o}, 7);
    check("R4 locked dq_oe", dq_oe_o, 0);
    we_n = 1'b1; cyc(2);
    check("R4 locked read dq_oe", dq_oe_o, 0);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_seal;
    t_narrow;
    t_wide;
    t_backup;
    t_filter;
    t_gating;
    finish_run;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run;
  end
endmodule